// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write path of a flash memory interface and turns bus write cycles (a word address plus a 16-bit data word) into commands. Some commands complete in a single write. Others open a sequence that a second write must finish, with the same address and a fitting second code. Each accepted command leaves the block as a one-cycle pulse on a one-hot operation vector, together with the address and data of the closing write. The write controller and the lock tracker pick up these pulses.

The block also keeps the read mode. This mode tells the read path whether a read returns array contents, identifier codes, query data or the status word. A broken sequence produces a pair of error pulses, one for the erase-error flag and one for the program-error flag. The status logic elsewhere sets both flags from that pair. Pin timing, query table contents and the execution of operations are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and on its release, `read_mode` is 0 (array) and `op_pulse`, `err_erase` and `err_prog` are all zero.
- R2: With no sequence open, a write whose low data byte is FFh, 90h, 98h or 70h sets `read_mode` to 0 (array), 1 (identifier), 2 (query) or 3 (status), visible one cycle after the write.
- R3: With no sequence open, low byte 50h pulses `op_pulse[7]` (clear status), B0h pulses `op_pulse[8]` (suspend) and D0h pulses `op_pulse[9]` (resume). Each pulse lasts one cycle and leaves `read_mode` unchanged.
- R4: 20h followed by D0h at the same address pulses `op_pulse[0]` (block erase). 30h followed by D0h at the same address pulses `op_pulse[1]` (chip erase). In both cases `op_addr` shows the address.
- R5: 40h or 10h, followed by any data word at the same address, pulses `op_pulse[2]` (program), with that word on `op_data` and the address on `op_addr`.
- R6: 60h followed at the same address by 01h, D0h or 2Fh pulses `op_pulse[4]` (set lock), `op_pulse[5]` (clear lock) or `op_pulse[6]` (set lock-down). `read_mode` is left unchanged.
- R7: A second write whose address differs from the first, or whose code does not fit the open sequence, pulses `err_erase` and `err_prog` together for one cycle. It pulses no operation, sets `read_mode` to 3 and closes the sequence.
- R8: Every accepted erase or program (`op_pulse` bits 0 to 3) sets `read_mode` to 3 (status). The mode stays there until a mode command is written.
- R9: C0h followed by a write at the same address in the range 80h to 88h inclusive pulses `op_pulse[3]` (OTP program). An address outside that range pulses only `err_prog` and sets `read_mode` to 3.
- R10: With no sequence open, any other first-cycle code is ignored: no pulse, and `read_mode` is unchanged.
- R11: Writes presented while `rst_n` is low are ignored. No pulse appears in a cycle that does not follow a write.
- R12: At most one `op_pulse` bit is set in any cycle. In the default configuration (`STRICT_HI=0`) the upper data byte plays no part in decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| op_pulse | output | 10 | One-hot operation pulse, bit map as in R3 to R9 |
| op_addr | output | AW | Address of the write that produced the last pulse |
| op_data | output | 16 | Data of the write that produced the last pulse |
| err_erase | output | 1 | Erase-error flag request pulse |
| err_prog | output | 1 | Program-error flag request pulse |

## Verification
Every result is registered once. The operation pulses, error pulses, `op_addr`, `op_data` and the new `read_mode` therefore all appear in the cycle right after the write edge, and a pulse is gone one cycle later. The bench drives each write on a falling edge, drops the strobe on the next falling edge, and samples at that moment. The pulse checks therefore land in the single cycle the pulse exists, and the check of the following write catches any pulse that lingers. The first write of a two-cycle sequence is checked for producing nothing, and the checks on the second write confirm that the block returns to idle.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_QUERY  = 2'd2,
      RM_STATUS = 2'd3
   } rmode_t;

   typedef enum logic [2:0] {
      PK_NONE, PK_ERASE_BLK, PK_ERASE_CHIP, PK_PROG, PK_OTP, PK_LOCK
   } pend_t;

   localparam int OP_N          = 10;
   localparam int OPB_ERASE_BLK = 0;
   localparam int OPB_ERASE_ALL = 1;
   localparam int OPB_PROG      = 2;
   localparam int OPB_OTP       = 3;
   localparam int OPB_LOCK_SET  = 4;
   localparam int OPB_LOCK_CLR  = 5;
   localparam int OPB_LOCK_DOWN = 6;
   localparam int OPB_CLR_STAT  = 7;
   localparam int OPB_SUSPEND   = 8;
   localparam int OPB_RESUME    = 9;

   localparam logic [7:0] OC_MODE_ARRAY  = 8'hFF;
   localparam logic [7:0] OC_MODE_STATUS = 8'h70;
   localparam logic [7:0] OC_MODE_IDENT  = 8'h90;
   localparam logic [7:0] OC_MODE_QUERY  = 8'h98;
   localparam logic [7:0] OC_CLR_STAT    = 8'h50;
   localparam logic [7:0] OC_SUSPEND     = 8'hB0;
   localparam logic [7:0] OC_CONFIRM     = 8'hD0;
   localparam logic [7:0] OC_ERASE_BLK   = 8'h20;
   localparam logic [7:0] OC_ERASE_ALL   = 8'h30;
   localparam logic [7:0] OC_PROG_A      = 8'h40;
   localparam logic [7:0] OC_PROG_B      = 8'h10;
   localparam logic [7:0] OC_OTP         = 8'hC0;
   localparam logic [7:0] OC_LOCK        = 8'h60;
   localparam logic [7:0] OC_LK_SET      = 8'h01;
   localparam logic [7:0] OC_LK_DOWN     = 8'h2F;

   typedef struct packed {
      logic            hit;
      logic            set_mode;
      rmode_t          mode;
      pend_t           pend;
      logic [OP_N-1:0] ops;
   } first_t;

endpackage

// File: rtl/fcd_classify.sv
`timescale 1ns/1ps
module fcd_classify
   import fcd_pkg::*;
(
   input  logic [7:0] cbyte,
   input  logic       code_ok,
   output first_t     res
);
   always_comb begin
      res      = '0;
      res.mode = RM_ARRAY;
      res.pend = PK_NONE;
      if (code_ok) begin
         res.hit = 1'b1;
         case (cbyte)
            OC_MODE_ARRAY:  begin res.set_mode = 1'b1; res.mode = RM_ARRAY;  end
            OC_MODE_STATUS: begin res.set_mode = 1'b1; res.mode = RM_STATUS; end
            OC_MODE_IDENT:  begin res.set_mode = 1'b1; res.mode = RM_IDENT;  end
            OC_MODE_QUERY:  begin res.set_mode = 1'b1; res.mode = RM_QUERY;  end
            OC_CLR_STAT:    res.ops[OPB_CLR_STAT] = 1'b1;
            OC_SUSPEND:     res.ops[OPB_SUSPEND]  = 1'b1;
            OC_CONFIRM:     res.ops[OPB_RESUME]   = 1'b1;
            OC_ERASE_BLK:   res.pend = PK_ERASE_BLK;
            OC_ERASE_ALL:   res.pend = PK_ERASE_CHIP;
            OC_PROG_A,
            OC_PROG_B:      res.pend = PK_PROG;
            OC_OTP:         res.pend = PK_OTP;
            OC_LOCK:        res.pend = PK_LOCK;
            default:        res.hit  = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/fcd_pending.sv
`timescale 1ns/1ps
module fcd_pending
   import fcd_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          clear,
   input  pend_t         pend_in,
   input  logic [AW-1:0] addr_in,
   output pend_t         pend_q,
   output logic [AW-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= PK_NONE;
         addr_q <= '0;
      end else if (load) begin
         pend_q <= pend_in;
         addr_q <= addr_in;
      end else if (clear) begin
         pend_q <= PK_NONE;
      end
   end
endmodule

// File: rtl/fcd_second.sv
`timescale 1ns/1ps
module fcd_second
   import fcd_pkg::*;
(
   input  pend_t           pend,
   input  logic [7:0]      cbyte,
   input  logic            code_ok,
   input  logic            addr_eq,
   input  logic            otp_ok,
   output logic [OP_N-1:0] ops,
   output logic            err_e,
   output logic            err_p,
   output logic            to_status
);
   logic confirm;
   assign confirm = code_ok && (cbyte == OC_CONFIRM);

   always_comb begin
      ops       = '0;
      err_e     = 1'b0;
      err_p     = 1'b0;
      to_status = 1'b0;
      if (!addr_eq) begin
         err_e     = 1'b1;
         err_p     = 1'b1;
         to_status = 1'b1;
      end else begin
         case (pend)
            PK_ERASE_BLK, PK_ERASE_CHIP: begin
               to_status = 1'b1;
               if (confirm) begin
                  if (pend == PK_ERASE_BLK) ops[OPB_ERASE_BLK] = 1'b1;
                  else                      ops[OPB_ERASE_ALL] = 1'b1;
               end else begin
                  err_e = 1'b1;
                  err_p = 1'b1;
               end
            end
            PK_PROG: begin
               to_status     = 1'b1;
               ops[OPB_PROG] = 1'b1;
            end
            PK_OTP: begin
               to_status = 1'b1;
               if (otp_ok) ops[OPB_OTP] = 1'b1;
               else        err_p = 1'b1;
            end
            PK_LOCK: begin
               if (code_ok && cbyte == OC_LK_SET)       ops[OPB_LOCK_SET]  = 1'b1;
               else if (confirm)                        ops[OPB_LOCK_CLR]  = 1'b1;
               else if (code_ok && cbyte == OC_LK_DOWN) ops[OPB_LOCK_DOWN] = 1'b1;
               else begin
                  err_e     = 1'b1;
                  err_p     = 1'b1;
                  to_status = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int          AW        = 20,
   parameter int unsigned OTP_LO    = 'h80,
   parameter int unsigned OTP_HI    = 'h88,
   parameter bit          STRICT_HI = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [15:0]   wr_data,
   output logic [1:0]    read_mode,
   output logic [9:0]    op_pulse,
   output logic [AW-1:0] op_addr,
   output logic [15:0]   op_data,
   output logic          err_erase,
   output logic          err_prog
);
   localparam logic [AW-1:0] OTP_LO_A = AW'(OTP_LO);
   localparam logic [AW-1:0] OTP_HI_A = AW'(OTP_HI);

   initial begin
      assert (AW >= 8 && AW <= 32) else $fatal(1, "AW out of range");
      assert (OTP_LO <= OTP_HI)    else $fatal(1, "OTP window inverted");
      assert (OP_N == 10)          else $fatal(1, "op vector width");
   end

   logic code_ok;
   generate
      if (STRICT_HI) begin : g_strict
         assign code_ok = (wr_data[15:8] == 8'h00);
      end else begin : g_loose
         assign code_ok = 1'b1;
      end
   endgenerate

   first_t f_res;
   fcd_classify u_cls (
      .cbyte   (wr_data[7:0]),
      .code_ok (code_ok),
      .res     (f_res)
   );

   pend_t         pend_q;
   logic [AW-1:0] pend_addr;
   logic          pend_load, pend_clr;
   fcd_pending #(.AW(AW)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pend_load),
      .clear   (pend_clr),
      .pend_in (f_res.pend),
      .addr_in (wr_addr),
      .pend_q  (pend_q),
      .addr_q  (pend_addr)
   );

   logic            addr_eq, otp_ok, in_seq;
   logic [OP_N-1:0] s_ops;
   logic            s_ee, s_ep, s_stat;
   assign addr_eq = (wr_addr == pend_addr);
   assign otp_ok  = (wr_addr >= OTP_LO_A) && (wr_addr <= OTP_HI_A);
   assign in_seq  = (pend_q != PK_NONE);

   fcd_second u_sec (
      .pend      (pend_q),
      .cbyte     (wr_data[7:0]),
      .code_ok   (code_ok),
      .addr_eq   (addr_eq),
      .otp_ok    (otp_ok),
      .ops       (s_ops),
      .err_e     (s_ee),
      .err_p     (s_ep),
      .to_status (s_stat)
   );

   rmode_t          mode_q, nx_mode;
   logic [OP_N-1:0] nx_ops;
   logic            nx_ee, nx_ep;

   always_comb begin
      nx_ops    = '0;
      nx_ee     = 1'b0;
      nx_ep     = 1'b0;
      nx_mode   = mode_q;
      pend_load = 1'b0;
      pend_clr  = 1'b0;
      if (wr_en) begin
         if (in_seq) begin
            pend_clr = 1'b1;
            nx_ops   = s_ops;
            nx_ee    = s_ee;
            nx_ep    = s_ep;
            if (s_stat) nx_mode = RM_STATUS;
         end else if (f_res.hit) begin
            nx_ops    = f_res.ops;
            pend_load = (f_res.pend != PK_NONE);
            if (f_res.set_mode) nx_mode = f_res.mode;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= RM_ARRAY;
         op_pulse  <= '0;
         err_erase <= 1'b0;
         err_prog  <= 1'b0;
         op_addr   <= '0;
         op_data   <= '0;
      end else begin
         mode_q    <= nx_mode;
         op_pulse  <= nx_ops;
         err_erase <= nx_ee;
         err_prog  <= nx_ep;
         if (|nx_ops) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
         end
      end
   end

   assign read_mode = mode_q;
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker #(
   parameter int          AW     = 20,
   parameter int unsigned OTP_LO = 'h80,
   parameter int unsigned OTP_HI = 'h88
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wr_lo,
   input logic [1:0]    read_mode,
   input logic [9:0]    op_pulse,
   input logic [AW-1:0] op_addr,
   input logic          err_erase,
   input logic          err_prog
);
   a_r12_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_pulse));

   a_r11_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (op_pulse == '0 && !err_erase && !err_prog));

   a_r7_error_pair: assert property (@(posedge clk) disable iff (!rst_n)
      err_erase |-> (err_prog && op_pulse == '0 && read_mode == 2'd3));

   a_r8_status_after_op: assert property (@(posedge clk) disable iff (!rst_n)
      (|op_pulse[3:0]) |-> read_mode == 2'd3);

   a_r9_otp_window: assert property (@(posedge clk) disable iff (!rst_n)
      op_pulse[3] |-> (op_addr >= AW'(OTP_LO) && op_addr <= AW'(OTP_HI)));

   a_r3_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
      op_pulse[7] |-> $past(wr_lo) == 8'h50);

   a_r3_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pulse[9] || op_pulse[8] || op_pulse[7]) |-> $stable(read_mode));
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .OTP_LO(OTP_LO), .OTP_HI(OTP_HI)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_lo     (wr_data[7:0]),
   .read_mode (read_mode),
   .op_pulse  (op_pulse),
   .op_addr   (op_addr),
   .err_erase (err_erase),
   .err_prog  (err_prog)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  read_mode;
   logic [9:0]  op_pulse;
   logic [19:0] op_addr;
   logic [15:0] op_data;
   logic        err_erase, err_prog;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   flash_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .read_mode(read_mode), .op_pulse(op_pulse), .op_addr(op_addr), .op_data(op_data),
      .err_erase(err_erase), .err_prog(err_prog)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at a falling edge, release at the next; outputs are then settled
   task automatic wr(input logic [19:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk_out(input string req, input logic [1:0] m, input logic [9:0] p,
                          input logic ee, input logic ep);
      chk({req, " mode"}, 32'(read_mode), 32'(m));
      chk({req, " ops"},  32'(op_pulse),  32'(p));
      chk({req, " errs"}, {30'd0, err_erase, err_prog}, {30'd0, ee, ep});
   endtask

   task automatic t_reset;
      chk_out("R1 reset", 2'd0, 10'd0, 1'b0, 1'b0);
      wr(20'h00010, 16'h0070);
      chk_out("R11 write in reset", 2'd0, 10'd0, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk_out("R1 after release", 2'd0, 10'd0, 1'b0, 1'b0);
   endtask

   task automatic t_modes;
      wr(20'h00001, 16'h0070); chk_out("R2 status", 2'd3, 10'd0, 1'b0, 1'b0);
      wr(20'h00002, 16'h0090); chk_out("R2 ident",  2'd1, 10'd0, 1'b0, 1'b0);
      wr(20'h00003, 16'h0012); chk_out("R10 reserved", 2'd1, 10'd0, 1'b0, 1'b0);
      wr(20'h00003, 16'h00E8); chk_out("R10 reserved2", 2'd1, 10'd0, 1'b0, 1'b0);
      wr(20'h00004, 16'hAB98); chk_out("R12 hi byte ignored", 2'd2, 10'd0, 1'b0, 1'b0);
      wr(20'h00005, 16'h00FF); chk_out("R2 array",  2'd0, 10'd0, 1'b0, 1'b0);
   endtask

   task automatic t_single;
      wr(20'h00100, 16'h0050); chk_out("R3 clear status", 2'd0, 10'h080, 1'b0, 1'b0);
      @(negedge clk);          chk_out("R3 one cycle",    2'd0, 10'h000, 1'b0, 1'b0);
      wr(20'h00100, 16'h00B0); chk_out("R3 suspend",      2'd0, 10'h100, 1'b0, 1'b0);
      wr(20'h00100, 16'h00D0); chk_out("R3 resume",       2'd0, 10'h200, 1'b0, 1'b0);
   endtask

   task automatic t_erase;
      wr(20'h23456, 16'h0020); chk_out("R4 erase setup", 2'd0, 10'h000, 1'b0, 1'b0);
      wr(20'h23456, 16'h00D0); chk_out("R4 block erase", 2'd3, 10'h001, 1'b0, 1'b0);
      chk("R4 erase addr", 32'(op_addr), 32'h23456);
      wr(20'h00000, 16'h00FF);
      wr(20'h00777, 16'h0030);
      wr(20'h00777, 16'h00D0); chk_out("R8 chip erase status", 2'd3, 10'h002, 1'b0, 1'b0);
   endtask

   task automatic t_prog;
      wr(20'h00000, 16'h00FF);
      wr(20'h4ABCD, 16'h0040);
      wr(20'h4ABCD, 16'hD0FF); chk_out("R5 program 40", 2'd3, 10'h004, 1'b0, 1'b0);
      chk("R5 program data", 32'(op_data), 32'hD0FF);
      chk("R5 program addr", 32'(op_addr), 32'h4ABCD);
      wr(20'h00009, 16'h0010);
      wr(20'h00009, 16'h0020); chk_out("R5 program 10", 2'd3, 10'h004, 1'b0, 1'b0);
      chk("R5 program data 10", 32'(op_data), 32'h0020);
   endtask

   task automatic t_lock;
      wr(20'h00000, 16'h00FF);
      wr(20'h30000, 16'h0060); wr(20'h30000, 16'h0001);
      chk_out("R6 set lock", 2'd0, 10'h010, 1'b0, 1'b0);
      wr(20'h30000, 16'h0060); wr(20'h30000, 16'h00D0);
      chk_out("R6 clear lock", 2'd0, 10'h020, 1'b0, 1'b0);
      wr(20'h30000, 16'h0060); wr(20'h30000, 16'h002F);
      chk_out("R6 lock-down", 2'd0, 10'h040, 1'b0, 1'b0);
   endtask

   task automatic t_errors;
      wr(20'h00000, 16'h00FF);
      wr(20'h10000, 16'h0020); wr(20'h10001, 16'h00D0);
      chk_out("R7 addr mismatch", 2'd3, 10'h000, 1'b1, 1'b1);
      wr(20'h00000, 16'h00FF); chk_out("R7 sequence closed", 2'd0, 10'h000, 1'b0, 1'b0);
      wr(20'h10000, 16'h0030); wr(20'h10000, 16'h0070);
      chk_out("R7 bad confirm", 2'd3, 10'h000, 1'b1, 1'b1);
      wr(20'h00000, 16'h00FF);
      wr(20'h20000, 16'h0060); wr(20'h20000, 16'h0002);
      chk_out("R7 bad lock code", 2'd3, 10'h000, 1'b1, 1'b1);
   endtask

   task automatic t_otp;
      wr(20'h00000, 16'h00FF);
      wr(20'h00080, 16'h00C0); wr(20'h00080, 16'h1111);
      chk_out("R9 otp low edge", 2'd3, 10'h008, 1'b0, 1'b0);
      wr(20'h00088, 16'h00C0); wr(20'h00088, 16'h2222);
      chk_out("R9 otp high edge", 2'd3, 10'h008, 1'b0, 1'b0);
      chk("R9 otp data", 32'(op_data), 32'h2222);
      wr(20'h00000, 16'h00FF);
      wr(20'h00089, 16'h00C0); wr(20'h00089, 16'h3333);
      chk_out("R9 otp outside", 2'd3, 10'h000, 1'b0, 1'b1);
      wr(20'h0007F, 16'h00C0); wr(20'h0007F, 16'h3333);
      chk_out("R9 otp below", 2'd3, 10'h000, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      t_modes;
      t_single;
      t_erase;
      t_prog;
      t_lock;
      t_errors;
      t_otp;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule